// File: doc/BRIEF.md
# Clamped Multi-Operand Adder with Cycle Latency

This block adds two or three signed integer operand buses and delivers the sum after a fixed number of clock cycles. A run-time select picks whether the third operand takes part. The sum is formed with enough guard bits that a three-way overflow is never lost. It is then either saturated to the full 32-bit signed range or clamped to a narrower range. The narrower range is a signed or unsigned window whose bit count is chosen at run time.

Latency and the active clock edge are build parameters. Every pipeline stage loads a parameterised initial value while reset is asserted. The output therefore shows that value until the first computed sum reaches the end of the pipeline. A typical use sums a current error sample with the previous sample, where the previous sample comes from an external one-cycle register.

Top module: `multi_add_lat`

## Requirements
- R1: With `ops3_i` = 0, the result is `op_a_i + op_b_i`, and `op_c_i` has no effect on the output.
- R2: With `ops3_i` = 1, the result is `op_a_i + op_b_i + op_c_i`.
- R3: With `lim_en_i` = 0, the result is the exact signed sum when it fits in 32 bits. Otherwise it saturates to 0x7FFFFFFF or 0x80000000. Overflow of a three-operand sum is detected correctly.
- R4: With `lim_en_i` = 1 and `lim_signed_i` = 0, the result is clamped to the range 0 to 2^N−1, where N is `lim_bits_i`. The value is zero-extended to 32 bits.
- R5: With `lim_en_i` = 1 and `lim_signed_i` = 1, the result is clamped to the range −2^(N−1) to 2^(N−1)−1. The value is sign-extended to 32 bits. An N of 0 is treated as N = 1.
- R6: Operands captured on active edge k appear on `sum_o` just after active edge k+S−1, where S = max(LATENCY,1). The output keeps its prior value on the edges before that.
- R7: `sum_o` changes only on the active edge. That is the rising edge of `clk_i` when TRIG_FALL = 0 and the falling edge when TRIG_FALL = 1.
- R8: While `rst_ni` is low, every stage and `sum_o` hold INIT_VAL. Reset takes effect without waiting for a clock edge. After release, `sum_o` stays at INIT_VAL until the first captured sum reaches the last stage.
- R9: LATENCY = 0 builds a single register stage. The sum of the operands captured on an active edge shows on `sum_o` right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, loads INIT_VAL |
| ops3_i | input | 1 | 1 = include third operand |
| lim_en_i | input | 1 | 1 = narrow clamp, 0 = full 32-bit saturation |
| lim_signed_i | input | 1 | Narrow clamp kind: 1 signed, 0 unsigned |
| lim_bits_i | input | $clog2(DATA_W) | Bit count N of the narrow range |
| op_a_i | input | DATA_W | Signed operand A |
| op_b_i | input | DATA_W | Signed operand B |
| op_c_i | input | DATA_W | Signed operand C |
| sum_o | output | DATA_W | Delayed, clamped result |

## Verification
Two builds are driven in parallel. One uses a three-stage rising-edge pipeline and the other a single-stage falling-edge pipeline, so latency and edge choice are told apart on the same stimulus.

The operand patterns cover several cases:
- mixed signs with a large third operand while it is deselected, which separates the two-operand mode from the three-operand mode;
- three maximum or three minimum operands, which only pass when the guard bits catch overflow beyond 33 bits;
- negative, in-range and oversized sums under 8-bit unsigned and signed windows, plus a zero bit count and a 31-bit window, which exercise each clamp bound.

Each new operand set is applied half a cycle before an edge, which shows both the cycles of stale output and the edge on which the new value lands. Reset is asserted both at start-up and in the middle of a run.

// File: rtl/multi_add_pkg.sv
package multi_add_pkg;

  localparam int MAX_OPS = 3;

  typedef enum logic {
    RNG_UNSIGNED = 1'b0,
    RNG_SIGNED   = 1'b1
  } rng_kind_e;

  function automatic int stage_count(input int lat);
    return (lat < 1) ? 1 : lat;
  endfunction

  function automatic int guard_bits(input int nops);
    return (nops < 2) ? 1 : $clog2(nops);
  endfunction

endpackage

// File: rtl/multi_add_sum.sv
module multi_add_sum
  import multi_add_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NOPS   = MAX_OPS,
  localparam int GUARD = guard_bits(NOPS),
  localparam int SUM_W = DATA_W + GUARD
) (
  input  logic [NOPS-1:0][DATA_W-1:0] ops_i,
  input  logic [NOPS-1:0]             use_i,
  output logic signed [SUM_W-1:0]     sum_o
);

  logic signed [SUM_W-1:0] ext [NOPS];

  for (genvar g = 0; g < NOPS; g++) begin : g_ext
    assign ext[g] = use_i[g] ? {{GUARD{ops_i[g][DATA_W-1]}}, ops_i[g]} : '0;
  end

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < NOPS; i++) sum_o = sum_o + ext[i];
  end

endmodule

// File: rtl/multi_add_clamp.sv
module multi_add_clamp
  import multi_add_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SUM_W  = 34,
  parameter int BITS_W = 5
) (
  input  logic signed [SUM_W-1:0] sum_i,
  input  logic                    lim_en_i,
  input  rng_kind_e               kind_i,
  input  logic [BITS_W-1:0]       bits_i,
  output logic [DATA_W-1:0]       res_o
);

  localparam logic signed [SUM_W-1:0] ONE     = 1;
  localparam logic signed [SUM_W-1:0] FULL_HI = (ONE <<< (DATA_W-1)) - ONE;
  localparam logic signed [SUM_W-1:0] FULL_LO = -(ONE <<< (DATA_W-1));

  logic [BITS_W-1:0]       n_eff;
  logic signed [SUM_W-1:0] hi, lo, res;

  always_comb begin
    n_eff = (bits_i == '0) ? BITS_W'(1) : bits_i;
    if (!lim_en_i) begin
      hi = FULL_HI;
      lo = FULL_LO;
    end else if (kind_i == RNG_SIGNED) begin
      hi = (ONE <<< (n_eff - BITS_W'(1))) - ONE;
      lo = -(ONE <<< (n_eff - BITS_W'(1)));
    end else begin
      hi = (ONE <<< n_eff) - ONE;
      lo = '0;
    end
    if (sum_i > hi)      res = hi;
    else if (sum_i < lo) res = lo;
    else                 res = sum_i;
    res_o = res[DATA_W-1:0];
  end

endmodule

// File: rtl/multi_add_delay.sv
module multi_add_delay #(
  parameter int           W         = 32,
  parameter int           STAGES    = 1,
  parameter bit           TRIG_FALL = 1'b0,
  parameter logic [W-1:0] INIT      = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic         clk_act;
  logic [W-1:0] pipe_q [STAGES];

  // falling-edge variant: same flops on the inverted clock
  assign clk_act = clk_i ^ TRIG_FALL;

  always_ff @(posedge clk_act or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= INIT;
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];

  p_capture_r6: assert property (@(posedge clk_act) disable iff (!rst_ni)
    $past(rst_ni) |-> pipe_q[0] == $past(d_i));

  for (genvar g = 1; g < STAGES; g++) begin : g_adv
    p_advance_r6: assert property (@(posedge clk_act) disable iff (!rst_ni)
      $past(rst_ni) |-> pipe_q[g] == $past(pipe_q[g-1]));
  end

  // reset check: only meaningful while reset is held
  p_init_r8: assert property (@(posedge clk_act)
    !rst_ni |-> q_o == INIT);

endmodule

// File: rtl/multi_add_lat.sv
module multi_add_lat
  import multi_add_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                LATENCY   = 3,
  parameter bit                TRIG_FALL = 1'b0,
  parameter logic [DATA_W-1:0] INIT_VAL  = '0,
  localparam int BITS_W = $clog2(DATA_W),
  localparam int STAGES = stage_count(LATENCY),
  localparam int SUM_W  = DATA_W + guard_bits(MAX_OPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ops3_i,
  input  logic              lim_en_i,
  input  logic              lim_signed_i,
  input  logic [BITS_W-1:0] lim_bits_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [DATA_W-1:0] op_c_i,
  output logic [DATA_W-1:0] sum_o
);

  logic [MAX_OPS-1:0][DATA_W-1:0] ops;
  logic [MAX_OPS-1:0]             use_ops;
  logic signed [SUM_W-1:0]        sum_w;
  logic [DATA_W-1:0]              clamp_w;

  assign ops     = {op_c_i, op_b_i, op_a_i};
  assign use_ops = {ops3_i, 1'b1, 1'b1};

  multi_add_sum #(.DATA_W(DATA_W), .NOPS(MAX_OPS)) u_sum (
    .ops_i (ops),
    .use_i (use_ops),
    .sum_o (sum_w)
  );

  multi_add_clamp #(.DATA_W(DATA_W), .SUM_W(SUM_W), .BITS_W(BITS_W)) u_clamp (
    .sum_i    (sum_w),
    .lim_en_i (lim_en_i),
    .kind_i   (rng_kind_e'(lim_signed_i)),
    .bits_i   (lim_bits_i),
    .res_o    (clamp_w)
  );

  multi_add_delay #(
    .W(DATA_W), .STAGES(STAGES), .TRIG_FALL(TRIG_FALL), .INIT(INIT_VAL)
  ) u_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (clamp_w),
    .q_o    (sum_o)
  );

  p_unsigned_floor_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_en_i && !lim_signed_i && sum_w < 0) |-> clamp_w == '0);

  p_signed_neg_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_en_i && lim_signed_i && sum_w < 0) |-> clamp_w[DATA_W-1]);

  p_full_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lim_en_i && (sum_w[SUM_W-1:DATA_W-1] == '0 || sum_w[SUM_W-1:DATA_W-1] == '1))
      |-> clamp_w == sum_w[DATA_W-1:0]);

  p_full_sat_hi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lim_en_i && !sum_w[SUM_W-1] && sum_w[SUM_W-2:DATA_W-1] != '0)
      |-> clamp_w == {1'b0, {(DATA_W-1){1'b1}}});

endmodule

// File: tb/multi_add_lat_bench.sv
module multi_add_lat_bench;

  localparam int          CLK_P  = 10;
  localparam logic [31:0] INIT_A = 32'hFFFF_FFFB;
  localparam logic [31:0] INIT_F = 32'd7;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic        ops3 = 1'b0, len = 1'b0, lsg = 1'b0;
  logic [4:0]  lbits = '0;
  logic [31:0] a = '0, b = '0, c = '0;
  logic [31:0] y_main, y_fall;
  int          checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  multi_add_lat #(.DATA_W(32), .LATENCY(3), .TRIG_FALL(1'b0), .INIT_VAL(INIT_A))
  u_multi_add_lat (
    .clk_i(clk), .rst_ni(rst_ni), .ops3_i(ops3), .lim_en_i(len), .lim_signed_i(lsg),
    .lim_bits_i(lbits), .op_a_i(a), .op_b_i(b), .op_c_i(c), .sum_o(y_main)
  );

  multi_add_lat #(.DATA_W(32), .LATENCY(0), .TRIG_FALL(1'b1), .INIT_VAL(INIT_F))
  u_multi_add_lat_fall (
    .clk_i(clk), .rst_ni(rst_ni), .ops3_i(ops3), .lim_en_i(len), .lim_signed_i(lsg),
    .lim_bits_i(lbits), .op_a_i(a), .op_b_i(b), .op_c_i(c), .sum_o(y_fall)
  );

  function automatic logic [31:0] model();
    longint s, hi, lo;
    int n;
    s = longint'($signed(a)) + longint'($signed(b)) + (ops3 ? longint'($signed(c)) : 64'sd0);
    if (!len) begin
      hi = 64'sd2147483647; lo = -64'sd2147483648;
    end else begin
      n = (lbits == 0) ? 1 : int'(lbits);
      if (lsg) begin hi = (64'sd1 <<< (n-1)) - 1; lo = -(64'sd1 <<< (n-1)); end
      else     begin hi = (64'sd1 <<< n) - 1;     lo = 0; end
    end
    if (s > hi) s = hi;
    else if (s < lo) s = lo;
    return s[31:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // new operands half a cycle before a rising edge
  task automatic run_case(input string req, input logic [31:0] na, nb, nc,
                          input logic n3, nl, ns, input logic [4:0] nbits);
    logic [31:0] prev, nw;
    prev = model();
    @(negedge clk); #2;
    a = na; b = nb; c = nc; ops3 = n3; len = nl; lsg = ns; lbits = nbits;
    nw = model();
    @(posedge clk); #1;
    chk("R7 fall holds at rising edge", y_fall, prev);
    chk("R6 main not yet updated", y_main, prev);
    #5 chk({req, " R9 fall one stage"}, y_fall, nw);
    @(posedge clk); #1 chk("R6 main still old", y_main, prev);
    @(posedge clk); #1 chk({req, " main"}, y_main, nw);
    #5 chk("R7 main holds at falling edge", y_main, nw);
  endtask

  task automatic init_hold();
    @(posedge clk); #1;
    chk("R8 main init after release", y_main, INIT_A);
    chk("R9 fall first result", y_fall, 32'd0);
    @(posedge clk); #1 chk("R8 main init held", y_main, INIT_A);
    @(posedge clk); #1 chk("R8 main first result", y_main, 32'd0);
  endtask

  task automatic t_release();
    @(posedge clk); #3 rst_ni = 1'b1;
    #1 chk("R8 fall init before edge", y_fall, INIT_F);
    init_hold();
  endtask

  task automatic t_reset_start();
    #1 rst_ni = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R8 main reset value", y_main, INIT_A);
    chk("R8 fall reset value", y_fall, INIT_F);
    t_release();
  endtask

  task automatic t_async_reset();
    @(posedge clk); #3;
    rst_ni = 1'b0;
    #1;
    chk("R8 main async reset", y_main, INIT_A);
    chk("R8 fall async reset", y_fall, INIT_F);
    a = '0; b = '0; c = '0; ops3 = 1'b0; len = 1'b0; lsg = 1'b0; lbits = '0;
    t_release();
  endtask

  task automatic t_two_three();
    run_case("R1 two operands, c ignored", 32'd100, -32'sd30, 32'd5000, 1'b0, 1'b0, 1'b0, 5'd0);
    run_case("R2 three operands", 32'd100, -32'sd30, 32'd5000, 1'b1, 1'b0, 1'b0, 5'd0);
    run_case("R2 three negatives", -32'sd7, -32'sd8, -32'sd9, 1'b1, 1'b0, 1'b0, 5'd0);
  endtask

  task automatic t_full_sat();
    run_case("R3 three max", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b0, 1'b0, 5'd0);
    run_case("R3 three min", 32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, 1'b0, 5'd0);
    run_case("R3 two-op overflow", 32'h7FFF_FFF0, 32'h20, 32'd0, 1'b0, 1'b0, 1'b0, 5'd0);
  endtask

  task automatic t_unsigned_lim();
    run_case("R4 negative to zero", -32'sd5, 32'd2, 32'd0, 1'b0, 1'b1, 1'b0, 5'd8);
    run_case("R4 over to 255", 32'd200, 32'd100, 32'd0, 1'b0, 1'b1, 1'b0, 5'd8);
    run_case("R4 in range", 32'd17, 32'd3, 32'd0, 1'b0, 1'b1, 1'b0, 5'd8);
    run_case("R4 31-bit cap", 32'h7FFF_FFFF, 32'd1, 32'd0, 1'b0, 1'b1, 1'b0, 5'd31);
  endtask

  task automatic t_signed_lim();
    run_case("R5 over to 127", 32'd200, 32'd0, 32'd0, 1'b0, 1'b1, 1'b1, 5'd8);
    run_case("R5 under to -128", -32'sd300, 32'd0, 32'd0, 1'b0, 1'b1, 1'b1, 5'd8);
    run_case("R5 in range", -32'sd20, 32'd5, 32'd0, 1'b0, 1'b1, 1'b1, 5'd8);
    run_case("R5 zero bits pos", 32'd5, 32'd0, 32'd0, 1'b0, 1'b1, 1'b1, 5'd0);
    run_case("R5 zero bits neg", -32'sd9, 32'd0, 32'd0, 1'b0, 1'b1, 1'b1, 5'd0);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_start();
    t_two_three();
    t_full_sat();
    t_unsigned_lim();
    t_signed_lim();
    t_async_reset();
    run_case("R2 after reset", 32'd1, 32'd2, 32'd3, 1'b1, 1'b0, 1'b0, 5'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule